// File: doc/BRIEF.md
# Forwarding Store Buffer with Visibility Events

This block sits between one processor and a shared single-port memory in a total-store-order system. Stores are queued in a small in-order buffer and written to memory later, oldest first, one per granted cycle. A load searches the buffer, and the newest queued store to the same address supplies its value. If no queued store matches, the load reads memory through the same port. A barrier pulse holds back later loads until every store queued ahead of it has reached memory.

For checking the memory model, the block splits every store into two timestamped events. A local event is raised when the store is queued. A global event is raised when the store is written to memory. Every load produces one event that reports whether the buffer or memory served it. Timestamps come from a free-running cycle counter. This lets a checker rebuild one visibility order, in which a processor sees its own stores early and all other agents see them in program order.

The store port and the load port are valid/ready. A store is taken in a cycle where `st_valid` and `st_ready` are both high, and `st_ready` falls only when the buffer is full. A load is taken when `ld_valid` and `ld_ready` are both high. `ld_ready` is low while a memory read is outstanding and while a barrier is holding loads. The requester keeps its valid and payload steady until the transfer happens. Events carry no back-pressure: each one is a single-cycle pulse. The memory side is a request/grant port. Read data must be valid in the same cycle as the grant.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset, `st_ready` and `ld_ready` are high, `mem_req` is low and all three event valids are low.
- R2: A store is taken only when `st_valid` and `st_ready` are both high. `st_ready` is low while DEPTH entries are queued. A store offered while the buffer is full is not taken: it raises no local event and never reaches memory.
- R3: One cycle after a store is taken, the local event pulses for exactly one cycle with kind 2, the store's address and data, `cpu_id`, and a timestamp equal to the counter value in the cycle the store was taken. The counter is 0 in the first cycle after reset and rises by one each cycle.
- R4: Queued stores go to memory oldest first, at most one per cycle, with `mem_req`=1 and `mem_we`=1, only in a cycle where `mem_gnt` is high. One cycle after each write, the global event pulses with kind 3, the written address and data, and the timestamp of the write cycle.
- R5: A load whose address matches a queued store responds one cycle after it is taken. The event has kind 1, and its data is the value of the youngest matching entry.
- R6: A load with no match reads memory with `mem_req`=1 and `mem_we`=0. It responds one cycle after the granted read, with kind 0 and the `mem_rdata` value seen at the grant.
- R7: When a load and a store are taken in the same cycle, the load is treated as older and does not see that store.
- R8: Only one load is in flight at a time: `ld_ready` is low while a memory read is outstanding. Such a read takes the port ahead of any drain, so no store written after the load was taken can affect it.
- R9: A pulse on `mbar` keeps `ld_ready` low, starting in the cycle of the pulse, until every store queued before the pulse has been written to memory. A load held this way then reads memory and does not forward from the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_id | input | PIDW | Processor number copied into every event |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load can be taken |
| ld_addr | input | AW | Load address |
| mbar | input | 1 | Memory barrier pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write (drain), 0 = read (load) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory grants the request this cycle |
| mem_rdata | input | DW | Read data, valid with the grant |
| loc_ev_valid | output | 1 | Local store event pulse |
| loc_ev_kind | output | 2 | Event kind (2) |
| loc_ev_addr | output | AW | Store address |
| loc_ev_data | output | DW | Store data |
| loc_ev_pid | output | PIDW | Processor number |
| loc_ev_ts | output | TSW | Cycle the store was queued |
| glb_ev_valid | output | 1 | Global store event pulse |
| glb_ev_kind | output | 2 | Event kind (3) |
| glb_ev_addr | output | AW | Address written |
| glb_ev_data | output | DW | Data written |
| glb_ev_pid | output | PIDW | Processor number |
| glb_ev_ts | output | TSW | Cycle the write was granted |
| ld_ev_valid | output | 1 | Load completion pulse |
| ld_ev_kind | output | 2 | 1 = served by buffer, 0 = served by memory |
| ld_ev_addr | output | AW | Load address |
| ld_ev_data | output | DW | Load value |
| ld_ev_pid | output | PIDW | Processor number |
| ld_ev_ts | output | TSW | Cycle the value was obtained |

## Verification
The bench queues three stores to one address mixed with other stores and checks that a load returns the newest one. A search that stops at the first or oldest match would return a stale value. It offers a store into a full buffer and later reads that address from memory, so a buffer that overwrote an entry or slipped past the full limit would show the stray value. It drains the buffer and checks that global events arrive in queue order on consecutive cycles. A barrier test relies on a buffered store that a plain load would forward: a design that ignored the barrier would answer from the buffer too early. A same-cycle store and load to one address checks that the load misses that store rather than forwarding a younger value.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    EV_LD_MEM    = 2'd0,
    EV_LD_BUF    = 2'd1,
    EV_ST_LOCAL  = 2'd2,
    EV_ST_GLOBAL = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] srch_addr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] slot(input logic [PW-1:0] base, input int k);
    int s;
    s = int'(base) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  assign count     = count_q;
  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];

  // Walk oldest to youngest so the youngest match is the one kept.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((k < int'(count_q)) && (addr_q[slot(head_q, k)] == srch_addr)) begin
        hit      = 1'b1;
        hit_data = data_q[slot(head_q, k)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= slot(tail_q, 1);
      if (pop)  head_q <= slot(head_q, 1);
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q != CW'(DEPTH)));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0));
endmodule

// File: rtl/sb_port.sv
module sb_port
  import sb_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int TSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TSW-1:0] ts,
  input  logic           ld_fire,
  input  logic [AW-1:0]  ld_addr,
  input  logic           hit,
  input  logic [DW-1:0]  hit_data,
  input  logic           fifo_empty,
  input  logic [AW-1:0]  head_addr,
  input  logic [DW-1:0]  head_data,
  input  logic           mem_gnt,
  input  logic [DW-1:0]  mem_rdata,
  output logic           busy,
  output logic           pop,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           rsp_valid,
  output logic [1:0]     rsp_kind,
  output logic [AW-1:0]  rsp_addr,
  output logic [DW-1:0]  rsp_data,
  output logic [TSW-1:0] rsp_ts
);
  logic          busy_q;
  logic [AW-1:0] raddr_q;

  assign busy = busy_q;

  // A pending read owns the port; drains use it otherwise.
  assign mem_req   = busy_q | ~fifo_empty;
  assign mem_we    = ~busy_q;
  assign mem_addr  = busy_q ? raddr_q : head_addr;
  assign mem_wdata = head_data;
  assign pop       = ~busy_q & ~fifo_empty & mem_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      raddr_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_kind  <= EV_LD_MEM;
      rsp_addr  <= '0;
      rsp_data  <= '0;
      rsp_ts    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (ld_fire && hit) begin
        rsp_valid <= 1'b1;
        rsp_kind  <= EV_LD_BUF;
        rsp_addr  <= ld_addr;
        rsp_data  <= hit_data;
        rsp_ts    <= ts;
      end else if (ld_fire) begin
        busy_q  <= 1'b1;
        raddr_q <= ld_addr;
      end
      if (busy_q && mem_gnt) begin
        busy_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_kind  <= EV_LD_MEM;
        rsp_addr  <= raddr_q;
        rsp_data  <= mem_rdata;
        rsp_ts    <= ts;
      end
    end
  end

  assert_one_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !ld_fire);
  assert_read_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (mem_req && !mem_we));
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int PIDW  = 2,
  parameter int TSW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PIDW-1:0] cpu_id,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic [AW-1:0]   ld_addr,
  input  logic            mbar,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_gnt,
  input  logic [DW-1:0]   mem_rdata,
  output logic            loc_ev_valid,
  output logic [1:0]      loc_ev_kind,
  output logic [AW-1:0]   loc_ev_addr,
  output logic [DW-1:0]   loc_ev_data,
  output logic [PIDW-1:0] loc_ev_pid,
  output logic [TSW-1:0]  loc_ev_ts,
  output logic            glb_ev_valid,
  output logic [1:0]      glb_ev_kind,
  output logic [AW-1:0]   glb_ev_addr,
  output logic [DW-1:0]   glb_ev_data,
  output logic [PIDW-1:0] glb_ev_pid,
  output logic [TSW-1:0]  glb_ev_ts,
  output logic            ld_ev_valid,
  output logic [1:0]      ld_ev_kind,
  output logic [AW-1:0]   ld_ev_addr,
  output logic [DW-1:0]   ld_ev_data,
  output logic [PIDW-1:0] ld_ev_pid,
  output logic [TSW-1:0]  ld_ev_ts
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [TSW-1:0] ts_q;
  logic [CW-1:0]  count, bar_left_q, bar_eff;
  logic           full, empty, hit, busy, pop, st_fire, ld_fire;
  logic [AW-1:0]  head_addr;
  logic [DW-1:0]  head_data, hit_data;

  assign st_ready = ~full;
  assign st_fire  = st_valid & st_ready;
  // Stores still ahead of the newest barrier; a barrier this cycle counts all.
  assign bar_eff  = mbar ? count : bar_left_q;
  assign ld_ready = ~busy & (bar_eff == '0);
  assign ld_fire  = ld_valid & ld_ready;

  sb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(st_fire), .push_addr(st_addr), .push_data(st_data),
    .pop(pop), .srch_addr(ld_addr),
    .count(count), .full(full), .empty(empty),
    .head_addr(head_addr), .head_data(head_data),
    .hit(hit), .hit_data(hit_data)
  );

  sb_port #(.AW(AW), .DW(DW), .TSW(TSW)) u_port (
    .clk(clk), .rst_n(rst_n), .ts(ts_q),
    .ld_fire(ld_fire), .ld_addr(ld_addr), .hit(hit), .hit_data(hit_data),
    .fifo_empty(empty), .head_addr(head_addr), .head_data(head_data),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .busy(busy), .pop(pop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rsp_valid(ld_ev_valid), .rsp_kind(ld_ev_kind), .rsp_addr(ld_ev_addr),
    .rsp_data(ld_ev_data), .rsp_ts(ld_ev_ts)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q         <= '0;
      bar_left_q   <= '0;
      loc_ev_valid <= 1'b0;
      loc_ev_addr  <= '0;
      loc_ev_data  <= '0;
      loc_ev_ts    <= '0;
      glb_ev_valid <= 1'b0;
      glb_ev_addr  <= '0;
      glb_ev_data  <= '0;
      glb_ev_ts    <= '0;
    end else begin
      ts_q       <= ts_q + 1'b1;
      bar_left_q <= (bar_eff == '0) ? '0 : bar_eff - CW'(pop);
      loc_ev_valid <= st_fire;
      if (st_fire) begin
        loc_ev_addr <= st_addr;
        loc_ev_data <= st_data;
        loc_ev_ts   <= ts_q;
      end
      glb_ev_valid <= pop;
      if (pop) begin
        glb_ev_addr <= head_addr;
        glb_ev_data <= head_data;
        glb_ev_ts   <= ts_q;
      end
    end
  end

  assign loc_ev_kind = EV_ST_LOCAL;
  assign glb_ev_kind = EV_ST_GLOBAL;
  assign loc_ev_pid  = cpu_id;
  assign glb_ev_pid  = cpu_id;
  assign ld_ev_pid   = cpu_id;

  assert_loc_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_ev_valid |-> $past(st_valid && st_ready));
  assert_drain_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    glb_ev_valid |-> $past(mem_req && mem_we && mem_gnt));
  assert_mem_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ev_valid && ld_ev_kind == EV_LD_MEM) |-> $past(mem_req && !mem_we && mem_gnt));
  assert_barrier_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_left_q != '0) |-> !ld_ready);
endmodule

// File: tb/tso_store_buffer_bench.sv
`timescale 1ns/1ps
module tso_store_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpu_id = 2'd2;
  logic        st_valid = 1'b0, ld_valid = 1'b0, mbar = 1'b0;
  logic [7:0]  st_addr = '0, ld_addr = '0;
  logic [15:0] st_data = '0;
  logic        st_ready, ld_ready, mem_req, mem_we, mem_gnt;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        loc_ev_valid, glb_ev_valid, ld_ev_valid;
  logic [1:0]  loc_ev_kind, glb_ev_kind, ld_ev_kind;
  logic [7:0]  loc_ev_addr, glb_ev_addr, ld_ev_addr;
  logic [15:0] loc_ev_data, glb_ev_data, ld_ev_data;
  logic [1:0]  loc_ev_pid, glb_ev_pid, ld_ev_pid;
  logic [15:0] loc_ev_ts, glb_ev_ts, ld_ev_ts;

  logic        gnt_en = 1'b0;
  logic [15:0] mem [256];
  logic [15:0] cyc;
  logic [15:0] last_glb_ts;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tso_store_buffer u_tso_store_buffer (.*);

  assign mem_rdata = mem[mem_addr];
  assign mem_gnt   = gnt_en | (mem_req & ~mem_we);

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_gnt) mem[mem_addr] <= mem_wdata;
    if (!rst_n) cyc <= '0; else cyc <= cyc + 1'b1;
  end
  always @(negedge clk) if (glb_ev_valid) last_glb_ts = glb_ev_ts;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    while (!st_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0;
    // R3: local event one cycle after acceptance
    chk(loc_ev_valid && loc_ev_kind == 2'd2 && loc_ev_pid == cpu_id, "R3 loc valid/kind/pid",
        {loc_ev_valid, loc_ev_kind, loc_ev_pid}, {1'b1, 2'd2, cpu_id});
    chk(loc_ev_addr == a && loc_ev_data == d && loc_ev_ts == cyc - 16'd1, "R3 loc addr/data/ts",
        {loc_ev_addr, loc_ev_data}, {a, d});
  endtask

  task automatic do_load(input logic [7:0] a, input logic [15:0] exp_d, input bit from_buf, input string req);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a;
    while (!ld_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    if (!from_buf) chk(!ld_ready && !ld_ev_valid, "R8 load in flight", {ld_ready, ld_ev_valid}, 0);
    for (int t = 0; t < 20; t++) begin
      if (ld_ev_valid) break;
      @(negedge clk);
    end
    chk(ld_ev_valid && ld_ev_data == exp_d && ld_ev_addr == a, req, ld_ev_data, exp_d);
    chk(ld_ev_kind == {1'b0, from_buf}, req, ld_ev_kind, {1'b0, from_buf});
  endtask

  // {store?, addr, data, expected load data, expected from buffer}
  localparam logic [41:0] VEC [10] = '{
    {1'b1, 8'h10, 16'h1111, 16'h0000, 1'b0},
    {1'b0, 8'h10, 16'h0000, 16'h1111, 1'b1},  // R5 hit
    {1'b0, 8'h20, 16'h0000, 16'hA020, 1'b0},  // R6 miss
    {1'b1, 8'h10, 16'h2222, 16'h0000, 1'b0},
    {1'b0, 8'h10, 16'h0000, 16'h2222, 1'b1},  // R5 youngest
    {1'b1, 8'h30, 16'h3333, 16'h0000, 1'b0},
    {1'b1, 8'h10, 16'h4444, 16'h0000, 1'b0},
    {1'b0, 8'h10, 16'h0000, 16'h4444, 1'b1},  // R5 youngest of three
    {1'b0, 8'h30, 16'h0000, 16'h3333, 1'b1},  // R5 other entry
    {1'b0, 8'h31, 16'h0000, 16'hA031, 1'b0}   // R6 miss with full buffer
  };

  initial begin
    logic [7:0]  g_addr [8];
    logic [15:0] g_data [8];
    logic [15:0] g_ts [8];
    int ng;
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(st_ready && ld_ready && !mem_req && !loc_ev_valid && !glb_ev_valid && !ld_ev_valid,
        "R1 reset state", {st_ready, ld_ready, mem_req, loc_ev_valid, glb_ev_valid, ld_ev_valid}, 6'b110000);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][41]) do_store(VEC[i][40:33], VEC[i][32:17]);
      else do_load(VEC[i][40:33], VEC[i][16:1], VEC[i][0], VEC[i][0] ? "R5 forward" : "R6 memory");
    end

    // R2: full buffer refuses a store
    @(negedge clk);
    chk(!st_ready, "R2 full ready low", st_ready, 0);
    st_valid = 1'b1; st_addr = 8'h77; st_data = 16'h7777;
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      chk(!loc_ev_valid, "R2 no event when full", loc_ev_valid, 0);
    end
    st_valid = 1'b0;

    // R4: drain in order, one per cycle
    gnt_en = 1'b1;
    ng = 0;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (glb_ev_valid && ng < 8) begin
        chk(glb_ev_ts == cyc - 16'd1 && glb_ev_kind == 2'd3, "R4 global ts/kind", glb_ev_ts, cyc - 16'd1);
        g_addr[ng] = glb_ev_addr; g_data[ng] = glb_ev_data; g_ts[ng] = glb_ev_ts; ng++;
      end
    end
    chk(ng == 4, "R4 drain count", ng, 4);
    chk(g_addr[0] == 8'h10 && g_data[0] == 16'h1111 && g_addr[2] == 8'h30 && g_data[2] == 16'h3333,
        "R4 order", {g_data[0], g_data[2]}, {16'h1111, 16'h3333});
    chk(g_data[1] == 16'h2222 && g_data[3] == 16'h4444 && g_ts[3] == g_ts[0] + 16'd3,
        "R4 back to back", {g_data[1], g_data[3]}, {16'h2222, 16'h4444});
    do_load(8'h10, 16'h4444, 1'b0, "R4 memory holds last store");
    do_load(8'h77, 16'hA077, 1'b0, "R2 refused store absent");

    // R9: barrier holds a load that would otherwise forward
    gnt_en = 1'b0;
    do_store(8'h40, 16'h5555);
    @(negedge clk);
    mbar = 1'b1; ld_valid = 1'b1; ld_addr = 8'h40;
    #1;
    chk(!ld_ready, "R9 blocked in pulse cycle", ld_ready, 0);
    @(negedge clk);
    mbar = 1'b0;
    for (int t = 0; t < 3; t++) begin
      chk(!ld_ready && !ld_ev_valid, "R9 still blocked", {ld_ready, ld_ev_valid}, 0);
      @(negedge clk);
    end
    gnt_en = 1'b1;
    for (int t = 0; t < 10; t++) begin
      if (ld_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    for (int t = 0; t < 20; t++) begin
      if (ld_ev_valid) break;
      @(negedge clk);
    end
    chk(ld_ev_valid && ld_ev_kind == 2'd0 && ld_ev_data == 16'h5555, "R9 load after drain",
        {ld_ev_kind, ld_ev_data}, {2'd0, 16'h5555});
    chk(ld_ev_ts > last_glb_ts, "R9 load after global event", ld_ev_ts, last_glb_ts);

    // R7: same-cycle store and load
    gnt_en = 1'b0;
    @(negedge clk);
    st_valid = 1'b1; st_addr = 8'h50; st_data = 16'h6666;
    ld_valid = 1'b1; ld_addr = 8'h50;
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0; ld_valid = 1'b0;
    chk(loc_ev_valid && loc_ev_data == 16'h6666, "R7 store taken", loc_ev_data, 16'h6666);
    for (int t = 0; t < 20; t++) begin
      if (ld_ev_valid) break;
      @(negedge clk);
    end
    chk(ld_ev_valid && ld_ev_kind == 2'd0 && ld_ev_data == 16'hA050, "R7 load misses same-cycle store",
        ld_ev_data, 16'hA050);
    do_load(8'h50, 16'h6666, 1'b1, "R5 later load forwards");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule